// File: doc/BRIEF.md
# Split-Carry Select Adder

This block adds two 8-bit operands and a carry input and presents the 9-bit result (8 sum bits plus a carry output) from a register one clock later. The lower nibble is summed by a 4-bit ripple chain that takes the external carry input.

The upper nibble is not made to wait for that chain. Two identical 4-bit chains sum it at the same time, one assuming an incoming carry of 0 and the other assuming 1. When the lower chain's carry settles, it acts as a single select line for five 2:1 multiplexers. Those multiplexers pick the upper four sum bits and the final carry from the matching chain.

The registered outputs let the block sit in a clocked datapath. A synchronous active-low reset clears the result register.

Top module: `split_carry_adder`

## Requirements
- R1: On any rising clock edge where `rst_n` is 0, `sum_q` and `cout_q` become 0.
- R2: On a rising clock edge where `rst_n` is 1, `{cout_q, sum_q}` takes the 9-bit value of `op_a + op_b + carry_in` as those inputs stood just before that edge, so the result appears one cycle after the operands.
- R3: `sum_q[3:0]` is the low 4 bits of `op_a[3:0] + op_b[3:0] + carry_in`. The internal carry out of that lower chain is bit 4 of the same sum.
- R4: The upper nibble is summed by two chains at once, with carry inputs fixed at 0 and 1. The 5-bit result (carry, sum) of the carry-1 chain always equals the carry-0 chain's result plus one.
- R5: When the lower chain's carry is 0, `sum_q[7:4]` and `cout_q` come from the carry-0 upper chain: `{cout_q, sum_q[7:4]} = op_a[7:4] + op_b[7:4]`.
- R6: When the lower chain's carry is 1, `sum_q[7:4]` and `cout_q` come from the carry-1 upper chain: `{cout_q, sum_q[7:4]} = op_a[7:4] + op_b[7:4] + 1`.
- R7: R2 holds for every one of the 2^17 combinations of `op_a`, `op_b` and `carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the result register loads on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_q | output | 8 | Registered sum |
| cout_q | output | 1 | Registered carry out of bit 7 |

## Verification
Each result is due exactly one rising edge after its operands are applied.

The bench drives a new operand set on every falling edge and puts it on a queue. On the next falling edge, one edge later, it pops that entry and compares the outputs against a value it computes from integer arithmetic.

A miscompare is attributed by position. A wrong low nibble is reported against R3. A wrong upper part is reported against R5 or R6, chosen by the carry the bench itself derives for the low half. A wrong upper part in cases where that carry ripples through a saturated upper nibble is reported against R4.

The reset checks sample one edge after the reset is asserted.

// File: rtl/sca_pkg.sv
// Shared sizing for the split-carry select adder.
// Assumes: the lower section width is less than the total width.
package sca_pkg;
    localparam int SCA_WIDTH = 8;
    localparam int SCA_LOW_W = 4;
endpackage

// File: rtl/sca_full_add.sv
// One-bit full adder cell.
// Does: sum = a ^ b ^ ci, co = a&b | ci&(a^b).
// Assumes: nothing; purely combinational.
module sca_full_add (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    logic p;

    // Propagate term, shared by the sum and the carry.
    always_comb p = a ^ b;

    // Sum and carry from the propagate and generate terms.
    always_comb begin
        s  = p ^ ci;
        co = (a & b) | (ci & p);
    end
endmodule

// File: rtl/sca_ripple.sv
// W-bit ripple-carry adder built from a chain of full adders.
// Does: {co, s} = a + b + ci.
// Assumes: W >= 1; the carry chain delay grows linearly with W.
module sca_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] chain;

    // The chain entry takes the section's carry input.
    always_comb chain[0] = ci;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            sca_full_add u_fa (
                .a (a[i]),
                .b (b[i]),
                .ci(chain[i]),
                .s (s[i]),
                .co(chain[i+1])
            );
        end
    endgenerate

    // The chain exit is the section's carry output.
    always_comb co = chain[W];
endmodule

// File: rtl/sca_pick.sv
// W-wide 2:1 selector: one 2:1 multiplexer per bit, all driven by a shared select line.
// Does: y = sel ? d1 : d0.
// Assumes: sel is a settled carry from the lower section.
module sca_pick #(
    parameter int W = 5
) (
    input  logic [W-1:0] d0,
    input  logic [W-1:0] d1,
    input  logic         sel,
    output logic [W-1:0] y
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_mux
            // Per-bit 2:1 selection.
            always_comb y[i] = sel ? d1[i] : d0[i];
        end
    endgenerate
endmodule

// File: rtl/split_carry_adder.sv
// Carry-select adder with a registered result.
// Does: the lower section ripples with carry_in. The upper section is summed twice,
// under carry-in 0 and carry-in 1, and the lower carry selects between the two.
// The result register loads every cycle; a synchronous active-low reset clears it.
// Assumes: WIDTH > LOW_W >= 1.
module split_carry_adder #(
    parameter int WIDTH = sca_pkg::SCA_WIDTH,
    parameter int LOW_W = sca_pkg::SCA_LOW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_q,
    output logic             cout_q
);
    localparam int HI_W = WIDTH - LOW_W;

    logic [LOW_W-1:0] lo_s;
    logic             lo_c;
    logic [HI_W-1:0]  hi_s [2];
    logic             hi_c [2];
    logic [HI_W:0]    hi_pick;

    // Lower section: ripples with the external carry.
    sca_ripple #(.W(LOW_W)) u_low (
        .a (op_a[LOW_W-1:0]),
        .b (op_b[LOW_W-1:0]),
        .ci(carry_in),
        .s (lo_s),
        .co(lo_c)
    );

    // Upper section: one chain per assumed carry, 0 and 1.
    genvar k;
    generate
        for (k = 0; k < 2; k++) begin : g_guess
            sca_ripple #(.W(HI_W)) u_high (
                .a (op_a[WIDTH-1:LOW_W]),
                .b (op_b[WIDTH-1:LOW_W]),
                .ci(k != 0),
                .s (hi_s[k]),
                .co(hi_c[k])
            );
        end
    endgenerate

    // Select stage: HI_W sum multiplexers plus one carry multiplexer.
    sca_pick #(.W(HI_W + 1)) u_pick (
        .d0 ({hi_c[0], hi_s[0]}),
        .d1 ({hi_c[1], hi_s[1]}),
        .sel(lo_c),
        .y  (hi_pick)
    );

    // Result register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q  <= '0;
            cout_q <= 1'b0;
        end else begin
            sum_q  <= {hi_pick[HI_W-1:0], lo_s};
            cout_q <= hi_pick[HI_W];
        end
    end

    // R1: a reset edge leaves the register cleared.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (sum_q == '0) && !cout_q);

    // R2: the registered result equals the arithmetic sum of the previous cycle's inputs.
    a_r2_registered_sum: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ({cout_q, sum_q} ==
                   ({1'b0, $past(op_a)} + {1'b0, $past(op_b)} + (WIDTH+1)'($past(carry_in)))));

    // R3: the lower section's outputs match its arithmetic sum.
    a_r3_low_section: assert property (@(posedge clk) disable iff (!rst_n)
        {lo_c, lo_s} == ({1'b0, op_a[LOW_W-1:0]} + {1'b0, op_b[LOW_W-1:0]}
                         + (LOW_W+1)'(carry_in)));

    // R4: the carry-1 chain's result is the carry-0 chain's result plus one.
    a_r4_guess_step: assert property (@(posedge clk) disable iff (!rst_n)
        {hi_c[1], hi_s[1]} == ({hi_c[0], hi_s[0]} + (HI_W+1)'(1)));

    // R4: a carry out of the carry-0 chain forces a carry out of the carry-1 chain.
    a_r4_carry_order: assert property (@(posedge clk) disable iff (!rst_n)
        hi_c[0] |-> hi_c[1]);
endmodule

// File: tb/tb_split_carry_adder.sv
module tb_split_carry_adder;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 1 << 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_a = '0;
    logic [7:0] op_b = '0;
    logic       carry_in = 1'b0;
    logic [7:0] sum_q;
    logic       cout_q;

    int applied = 0;
    int errors  = 0;
    int checks  = 0;
    logic [16:0] pend [$];

    split_carry_adder dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .carry_in(carry_in), .sum_q(sum_q), .cout_q(cout_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        finish_run();
    end

    // R1: the outputs must read zero after reset.
    task automatic check_reset(string tag);
        checks++;
        if (sum_q !== 8'h00 || cout_q !== 1'b0) begin
            errors++;
            $display("FAIL R1 %s: actual %b_%h expected 0_00", tag, cout_q, sum_q);
        end
    endtask

    // Pop the oldest pending vector and compare it against integer arithmetic.
    task automatic check_one();
        logic [16:0] v;
        int a, b, c, exp, lo_exp, lo_carry, hi_sum;
        v = pend.pop_front();
        a = int'(v[16:9]); b = int'(v[8:1]); c = int'(v[0]);
        exp      = a + b + c;
        lo_exp   = (a % 16) + (b % 16) + c;
        lo_carry = lo_exp / 16;
        hi_sum   = (a / 16) + (b / 16);
        checks++;
        if ({cout_q, sum_q} !== 9'(exp)) begin
            errors++;
            if (sum_q[3:0] !== 4'(lo_exp))
                $display("FAIL R3 a=%h b=%h ci=%0d: actual %b_%h expected %h",
                         a, b, c, cout_q, sum_q, 9'(exp));
            else if (lo_carry == 1 && hi_sum == 15)
                $display("FAIL R4/R6 a=%h b=%h ci=%0d: actual %b_%h expected %h",
                         a, b, c, cout_q, sum_q, 9'(exp));
            else if (lo_carry == 1)
                $display("FAIL R6 a=%h b=%h ci=%0d: actual %b_%h expected %h",
                         a, b, c, cout_q, sum_q, 9'(exp));
            else
                $display("FAIL R5 a=%h b=%h ci=%0d: actual %b_%h expected %h",
                         a, b, c, cout_q, sum_q, 9'(exp));
        end
    endtask

    initial begin
        // R1: reset with non-zero inputs present.
        op_a = 8'hff; op_b = 8'hff; carry_in = 1'b1;
        repeat (3) @(negedge clk);
        check_reset("initial");
        rst_n = 1'b1;
        // R2, R7: one vector per cycle, each checked one edge later.
        for (int i = 0; i < NVEC; i++) begin
            if (pend.size() != 0) check_one();
            op_a     = 8'(i >> 9);
            op_b     = 8'(i >> 1);
            carry_in = i[0];
            pend.push_back(17'(i));
            applied++;
            @(negedge clk);
        end
        check_one();
        // R7: every combination was compared.
        checks++;
        if (checks != NVEC + 2) begin
            errors++;
            $display("FAIL R7 coverage: actual %0d expected %0d", checks, NVEC + 2);
        end
        // R1: reset again mid-operation.
        op_a = 8'h80; op_b = 8'h80; carry_in = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check_reset("second");
        finish_run();
    end
endmodule